// File: doc/BRIEF.md
# Slot-Assigned Stereo Serial Frame Engine

This block is a master-mode serial audio port. It generates a serial bit clock and a frame-sync line itself. Once per frame it shifts a pair of 16-bit left/right words out on the data-out line and collects a pair of 16-bit words from the data-in line. Each frame is made of 16-bit slots, counted from 0 at the start of the frame. A frame holds either two slots (32 bits) or four slots (64 bits).

Four channels can each be placed in a slot of their own: left transmit, right transmit, left receive and right receive. Each has a 4-bit slot number and an enable. Because of this, the transmit and receive words of one side can use different slots. A typical two-slot setup puts both left channels in slot 0 and both right channels in slot 1. A typical four-slot setup uses slot 0 for left transmit, slot 1 for left receive, slot 2 for right transmit and slot 3 for right receive.

On the parallel side, a one-entry holding register takes one transmit pair through a valid/ready handshake. The pair is applied at the next frame start. If no pair is waiting when a frame starts, the previous words are sent again and an underrun pulse is raised. The received pair is presented after the last bit of each frame. The sync line runs as a left/right channel clock, and a select input picks which serial clock edge samples the input.

Top module: `stereo_slot_port`

## Requirements
- R1: While reset is asserted and until the first serial edge, sck, sync and txd are 0, rx_valid and tx_underrun are 0, tx_ready is 1 and both received words are 0.
- R2: sck is a free-running clock with a period of 2*HALF_DIV system clocks. long_frame=0 selects a 32-bit frame (2 slots) and long_frame=1 selects a 64-bit frame (4 slots).
- R3: sync is high for the first half of every frame and low for the second half. It rises on the same serial edge that presents the first bit of slot 0, with no one-bit delay.
- R4: Slot n covers frame bits 16n to 16n+15. Words are sent and received MSB first.
- R5: Each of the four channels uses its own 4-bit slot number when its enable is 1. A slot number at or beyond the slot count of the frame is never used.
- R6: In a bit whose slot has no enabled transmit channel, txd is 0. When both transmit channels name the same slot, the left word is sent.
- R7: A receive channel whose enable is 0 captures nothing: its output word keeps its previous value, which is 0 after reset.
- R8: With rise_sample=1, rxd is sampled on the rising sck edge, and txd and sync change only on the falling edge. With rise_sample=0 the two edges swap roles.
- R9: A transmit pair is taken when tx_valid and tx_ready are both 1. tx_ready then stays 0 until the next frame start, and that frame sends the pair.
- R10: If no pair is held when a frame starts, that frame repeats the previous words (zeros after reset), and tx_underrun is high for exactly one cycle.
- R11: After the last bit of a frame, the received pair appears with rx_valid=1. rx_valid stays 1 until rx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_frame | input | 1 | 0: 32-bit frame, 1: 64-bit frame |
| rise_sample | input | 1 | 1: sample rxd on rising sck, 0: on falling sck |
| tx_l_en | input | 1 | Left transmit enable |
| tx_l_slot | input | 4 | Left transmit slot number |
| tx_r_en | input | 1 | Right transmit enable |
| tx_r_slot | input | 4 | Right transmit slot number |
| rx_l_en | input | 1 | Left receive enable |
| rx_l_slot | input | 4 | Left receive slot number |
| rx_r_en | input | 1 | Right receive enable |
| rx_r_slot | input | 4 | Right receive slot number |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Holding register empty |
| tx_left | input | 16 | Left transmit word |
| tx_right | input | 16 | Right transmit word |
| tx_underrun | output | 1 | One-cycle pulse: frame started with no new pair |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Received pair taken |
| rx_left | output | 16 | Left received word |
| rx_right | output | 16 | Right received word |
| sck | output | 1 | Serial bit clock |
| sync | output | 1 | Frame sync, left/right channel clock |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The frame engine is run with the two standard stereo layouts, with both sampling edges, with every channel disabled, with two transmit channels placed in one slot, with a receive slot beyond the short frame, and with randomly drawn slot numbers and enables. The standard layouts show whether slot counting and MSB-first order are correct. The collision and out-of-range cases show whether the priority and the frame bound are enforced. The edge swap shows whether launch and sample edges are kept apart. Every run sends a new pair in frames two and three and no pair in frame four, which separates taking a new pair from repeating the old one and places each underrun pulse.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int SLOT_W    = 4;
  localparam int MIN_SLOTS = 2;
  localparam int MAX_SLOTS = 4;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
  } chan_cfg_t;

  // Number of serial bits in one frame for the selected length.
  function automatic int frame_bits(input logic long_frame, input int word_w);
    return (long_frame ? MAX_SLOTS : MIN_SLOTS) * word_w;
  endfunction

  // A channel owns the current slot when enabled and its number matches.
  function automatic logic slot_hit(input chan_cfg_t cfg, input logic [SLOT_W-1:0] cur);
    return cfg.en && (cfg.slot == cur);
  endfunction
endpackage

// File: rtl/sfe_clkgen.sv
module sfe_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap     = (cnt == CNT_W'(HALF_DIV - 1));
  assign rise_evt = wrap && !sck;
  assign fall_evt = wrap && sck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfe_tx_path.sv
module sfe_tx_path
  import sfe_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              running,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic [BIT_W-1:0]  bit_idx,
  input  chan_cfg_t         cfg_l,
  input  chan_cfg_t         cfg_r,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              tx_ready,
  output logic              tx_underrun,
  output logic              txd
);
  logic [WORD_W-1:0] pend_l, pend_r, act_l, act_r;
  logic              pend_full, accept, hit_l, hit_r;
  logic [BIT_W-1:0]  msb_idx;

  assign tx_ready = !pend_full;
  assign accept   = tx_valid && !pend_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_l      <= '0;
      pend_r      <= '0;
      act_l       <= '0;
      act_r       <= '0;
      pend_full   <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      tx_underrun <= frame_start && !pend_full;
      if (frame_start && pend_full) begin
        act_l     <= pend_l;
        act_r     <= pend_r;
        pend_full <= 1'b0;
      end else if (accept) begin
        pend_l    <= tx_left;
        pend_r    <= tx_right;
        pend_full <= 1'b1;
      end
    end
  end

  // WORD_W is a power of two, so the MSB-first bit index is the complement.
  assign msb_idx = ~bit_idx;
  assign hit_l   = slot_hit(cfg_l, cur_slot);
  assign hit_r   = slot_hit(cfg_r, cur_slot);

  always_comb begin
    txd = 1'b0;
    if (running) begin
      if (hit_l)      txd = act_l[msb_idx];
      else if (hit_r) txd = act_r[msb_idx];
    end
  end
endmodule

// File: rtl/sfe_rx_path.sv
module sfe_rx_path
  import sfe_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_evt,
  input  logic              running,
  input  logic              frame_end,
  input  logic [SLOT_W-1:0] cur_slot,
  input  chan_cfg_t         cfg_l,
  input  chan_cfg_t         cfg_r,
  input  logic              rxd,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right
);
  logic [WORD_W-1:0] sh_l, sh_r, nxt_l, nxt_r;
  logic              cap_l, cap_r;

  assign cap_l = sample_evt && running && slot_hit(cfg_l, cur_slot);
  assign cap_r = sample_evt && running && slot_hit(cfg_r, cur_slot);
  assign nxt_l = {sh_l[WORD_W-2:0], rxd};
  assign nxt_r = {sh_r[WORD_W-2:0], rxd};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_l     <= '0;
      sh_r     <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (cap_l) sh_l <= nxt_l;
      if (cap_r) sh_r <= nxt_r;
      if (frame_end) begin
        rx_left  <= cap_l ? nxt_l : sh_l;
        rx_right <= cap_r ? nxt_r : sh_r;
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stereo_slot_port.sv
module stereo_slot_port
  import sfe_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_frame,
  input  logic              rise_sample,
  input  logic              tx_l_en,
  input  logic [3:0]        tx_l_slot,
  input  logic              tx_r_en,
  input  logic [3:0]        tx_r_slot,
  input  logic              rx_l_en,
  input  logic [3:0]        rx_l_slot,
  input  logic              rx_r_en,
  input  logic [3:0]        rx_r_slot,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              tx_underrun,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              sck,
  output logic              sync,
  output logic              txd,
  input  logic              rxd
);
  localparam int BIT_W    = $clog2(WORD_W);
  localparam int MAX_BITS = MAX_SLOTS * WORD_W;
  localparam int POS_W    = $clog2(MAX_BITS);

  // Named internal events, also watched by the bound checker.
  logic              rise_evt, fall_evt, launch_evt, sample_evt;
  logic              running, frame_start, frame_end;
  logic [POS_W-1:0]  pos, last_pos, half_pos;
  logic [SLOT_W-1:0] cur_slot;
  logic [BIT_W-1:0]  bit_idx;
  chan_cfg_t         cfg_txl, cfg_txr, cfg_rxl, cfg_rxr;

  assign cfg_txl = '{en: tx_l_en, slot: tx_l_slot};
  assign cfg_txr = '{en: tx_r_en, slot: tx_r_slot};
  assign cfg_rxl = '{en: rx_l_en, slot: rx_l_slot};
  assign cfg_rxr = '{en: rx_r_en, slot: rx_r_slot};

  sfe_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .sck(sck), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  // The edge that launches data is the one not used for sampling.
  assign launch_evt = rise_sample ? fall_evt : rise_evt;
  assign sample_evt = rise_sample ? rise_evt : fall_evt;

  assign last_pos    = POS_W'(frame_bits(long_frame, WORD_W) - 1);
  assign half_pos    = POS_W'(frame_bits(long_frame, WORD_W) / 2);
  assign frame_start = launch_evt && (!running || pos >= last_pos);
  assign frame_end   = sample_evt && running && (pos == last_pos);
  assign cur_slot    = SLOT_W'(pos >> BIT_W);
  assign bit_idx     = pos[BIT_W-1:0];
  assign sync        = running && (pos < half_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      pos     <= '0;
    end else if (launch_evt) begin
      running <= 1'b1;
      pos     <= frame_start ? '0 : pos + 1'b1;
    end
  end

  sfe_tx_path #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .running(running),
    .cur_slot(cur_slot), .bit_idx(bit_idx), .cfg_l(cfg_txl), .cfg_r(cfg_txr),
    .tx_valid(tx_valid), .tx_left(tx_left), .tx_right(tx_right),
    .tx_ready(tx_ready), .tx_underrun(tx_underrun), .txd(txd)
  );

  sfe_rx_path #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .running(running),
    .frame_end(frame_end), .cur_slot(cur_slot), .cfg_l(cfg_rxl), .cfg_r(cfg_rxr),
    .rxd(rxd), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_left(rx_left), .rx_right(rx_right)
  );
endmodule

// File: rtl/stereo_slot_port_chk.sv
module stereo_slot_port_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic sync,
  input logic txd,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_underrun,
  input logic rx_valid,
  input logic rx_ready,
  input logic launch_evt,
  input logic rise_evt,
  input logic fall_evt,
  input logic frame_start
);
  p_sck_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $past(rise_evt));
  p_sck_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> $past(fall_evt));
  p_sync_at_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(launch_evt) |-> $stable(sync));
  p_sync_rise_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(frame_start));
  p_txd_at_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(launch_evt) |-> $stable(txd));
  p_hold_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  p_underrun_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> $past(frame_start));
  p_underrun_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> !tx_underrun);
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);
endmodule

bind stereo_slot_port stereo_slot_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .sync(sync), .txd(txd),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underrun(tx_underrun),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .launch_evt(launch_evt),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .frame_start(frame_start)
);

// File: tb/stereo_slot_port_bench.sv
module stereo_slot_port_bench;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic long_frame = 1'b0, rise_sample = 1'b1;
  logic tx_l_en = 1'b0, tx_r_en = 1'b0, rx_l_en = 1'b0, rx_r_en = 1'b0;
  logic [3:0] tx_l_slot = '0, tx_r_slot = '0, rx_l_slot = '0, rx_r_slot = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b1, rxd;
  logic [15:0] tx_left = '0, tx_right = '0;
  logic tx_ready, tx_underrun, rx_valid, sck, sync, txd;
  logic [15:0] rx_left, rx_right;

  int checks = 0, failures = 0;

  // Monitor state
  logic [63:0] rx_pat = '0, tx_cap;
  logic [63:0] tx_frames [0:7];
  logic prev_sck, prev_sync, prev_txd, in_frame;
  int idx, frame_cnt, under_cnt, rx_cnt, sync_err, edge_err, clk_err, cyc, last_rise;
  logic [15:0] rx_l_log, rx_r_log;

  always #5 clk = ~clk;

  stereo_slot_port #(.WORD_W(16), .HALF_DIV(HALF)) u_stereo_slot_port (
    .clk(clk), .rst_n(rst_n), .long_frame(long_frame), .rise_sample(rise_sample),
    .tx_l_en(tx_l_en), .tx_l_slot(tx_l_slot), .tx_r_en(tx_r_en), .tx_r_slot(tx_r_slot),
    .rx_l_en(rx_l_en), .rx_l_slot(rx_l_slot), .rx_r_en(rx_r_en), .rx_r_slot(rx_r_slot),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right),
    .tx_underrun(tx_underrun), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_left(rx_left), .rx_right(rx_right), .sck(sck), .sync(sync), .txd(txd), .rxd(rxd)
  );

  // Serial-side model: codec that drives rxd on launch edges, captures txd on sample edges.
  always @(negedge clk) begin
    int fb;
    logic edge_seen, is_launch, is_sample;
    fb = long_frame ? 64 : 32;
    if (!rst_n) begin
      in_frame = 1'b0; idx = 0; frame_cnt = 0; under_cnt = 0; rx_cnt = 0;
      sync_err = 0; edge_err = 0; clk_err = 0; cyc = 0; last_rise = -1;
      tx_cap = '0; rxd = 1'b0; rx_l_log = '0; rx_r_log = '0;
    end else begin
      cyc++;
      edge_seen = (sck != prev_sck);
      is_launch = edge_seen && (rise_sample ? !sck : sck);
      is_sample = edge_seen && !is_launch;
      if (edge_seen && sck) begin
        if (last_rise >= 0 && (cyc - last_rise) != 2 * HALF) clk_err++;
        last_rise = cyc;
      end
      if (!is_launch && (txd != prev_txd || sync != prev_sync)) edge_err++;
      if (is_launch) begin
        if (sync && !prev_sync) begin idx = 0; in_frame = 1'b1; tx_cap = '0; end
        else idx++;
        if (in_frame && idx < 64) rxd = rx_pat[63 - idx];
      end
      if (is_sample && in_frame && idx < 64) begin
        tx_cap[63 - idx] = txd;
        if (sync != (idx < fb / 2)) sync_err++;
        if (idx == fb - 1) begin
          if (frame_cnt < 8) tx_frames[frame_cnt] = tx_cap;
          frame_cnt++;
        end
      end
      if (tx_underrun) under_cnt++;
      if (rx_valid && rx_ready) begin rx_l_log = rx_left; rx_r_log = rx_right; rx_cnt++; end
    end
    prev_sck = sck; prev_sync = sync; prev_txd = txd;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected serial frame, first bit at position 63.
  function automatic logic [63:0] exp_tx(input logic lf, input logic le, input logic [3:0] ls,
      input logic re, input logic [3:0] rs, input logic [15:0] lw, input logic [15:0] rw);
    logic [63:0] v = '0;
    int nbits = lf ? 64 : 32;
    for (int i = 0; i < nbits; i++) begin
      int s = i / 16;
      int b = 15 - (i % 16);
      if (le && int'(ls) == s)      v[63 - i] = lw[b];
      else if (re && int'(rs) == s) v[63 - i] = rw[b];
    end
    return v;
  endfunction

  function automatic logic [15:0] exp_rx(input logic en, input logic [3:0] slot,
      input logic lf, input logic [63:0] pat);
    int ns = lf ? 4 : 2;
    if (!en || int'(slot) >= ns) return 16'h0000;
    return pat[63 - 16 * int'(slot) -: 16];
  endfunction

  task automatic send_pair(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    tx_valid = 1'b1; tx_left = l; tx_right = r;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic run_scn(input string name, input logic lf, input logic rs,
      input logic tle, input logic [3:0] tls, input logic tre, input logic [3:0] trs,
      input logic rle, input logic [3:0] rls, input logic rre, input logic [3:0] rrs,
      input bit reset_chk, input bit hold_chk);
    logic [15:0] al, ar, bl, br;
    @(negedge clk);
    rst_n = 1'b0;
    long_frame = lf; rise_sample = rs;
    tx_l_en = tle; tx_l_slot = tls; tx_r_en = tre; tx_r_slot = trs;
    rx_l_en = rle; rx_l_slot = rls; rx_r_en = rre; rx_r_slot = rrs;
    rx_ready = 1'b1; tx_valid = 1'b0;
    rx_pat = {$urandom, $urandom};
    al = 16'($urandom); ar = 16'($urandom); bl = 16'($urandom); br = 16'($urandom);
    repeat (3) @(negedge clk);
    if (reset_chk) begin
      chk("R1 reset outputs", {58'd0, sck, sync, txd, rx_valid, tx_underrun, tx_ready}, 64'h1);
      chk("R1 reset rx words", {32'd0, rx_left, rx_right}, 64'h0);
    end
    rst_n = 1'b1;
    wait (in_frame);
    send_pair(al, ar);
    chk({"R9 ready low while held ", name}, {63'd0, tx_ready}, 64'h0);
    send_pair(bl, br);
    wait (frame_cnt >= 4);
    chk({"R10 first frame repeats reset words ", name}, tx_frames[0],
        exp_tx(lf, tle, tls, tre, trs, 16'h0, 16'h0));
    chk({"R4 R5 R6 frame with pair A ", name}, tx_frames[1],
        exp_tx(lf, tle, tls, tre, trs, al, ar));
    chk({"R9 frame with pair B ", name}, tx_frames[2],
        exp_tx(lf, tle, tls, tre, trs, bl, br));
    chk({"R10 repeat after no pair ", name}, tx_frames[3],
        exp_tx(lf, tle, tls, tre, trs, bl, br));
    chk({"R10 underrun pulses ", name}, 64'(under_cnt), 64'd2);
    chk({"R5 R7 R8 rx left ", name}, {48'd0, rx_l_log}, {48'd0, exp_rx(rle, rls, lf, rx_pat)});
    chk({"R5 R7 R8 rx right ", name}, {48'd0, rx_r_log}, {48'd0, exp_rx(rre, rrs, lf, rx_pat)});
    chk({"R11 rx pairs seen ", name}, 64'(rx_cnt >= 3), 64'd1);
    chk({"R3 sync halves ", name}, 64'(sync_err), 64'd0);
    chk({"R8 launch-edge only changes ", name}, 64'(edge_err), 64'd0);
    chk({"R2 sck period ", name}, 64'(clk_err), 64'd0);
    if (hold_chk) begin
      rx_ready = 1'b0;
      wait (frame_cnt >= 5);
      repeat (3) @(negedge clk);
      chk("R11 valid set after frame", {63'd0, rx_valid}, 64'd1);
      repeat (5) @(negedge clk);
      chk("R11 valid held without ready", {63'd0, rx_valid}, 64'd1);
      rx_ready = 1'b1;
      @(negedge clk);
      chk("R11 valid drops after ready", {63'd0, rx_valid}, 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    run_scn("two-slot stereo", 1'b0, 1'b1, 1, 0, 1, 1, 1, 0, 1, 1, 1'b1, 1'b1);
    run_scn("four-slot split", 1'b1, 1'b1, 1, 0, 1, 2, 1, 1, 1, 3, 1'b0, 1'b0);
    run_scn("four-slot falling", 1'b1, 1'b0, 1, 0, 1, 2, 1, 1, 1, 3, 1'b0, 1'b0);
    run_scn("all disabled", 1'b1, 1'b0, 0, 0, 0, 1, 0, 2, 0, 3, 1'b0, 1'b0);
    run_scn("collision R6 and out-of-range R5", 1'b0, 1'b0, 1, 1, 1, 1, 1, 3, 1, 0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      run_scn($sformatf("random %0d", k), 1'($urandom), 1'($urandom),
              1'($urandom), 4'($urandom % 5), 1'($urandom), 4'($urandom % 5),
              1'($urandom), 4'($urandom % 5), 1'($urandom), 4'($urandom % 5), 1'b0, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R1-all actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule